// File: doc/BRIEF.md
# Trigger Counter/Timer Resource

This block provides a bank of wide count registers that a trigger sequencer uses as event sources. Each unit works either as an up/down event counter or as an elapsed-time timer. The sequencer drives one-cycle command pulses into a unit. In counter mode the unit steps its value up or down on each commanded event. In timer mode the unit advances by one on every sample-clock cycle while it is running. Each unit compares its value with a programmed terminal value, and the result is a match flag that the sequencer takes back as an event.

A small write port selects the mode of each unit and loads its terminal value. A combinational read port returns the current value of any unit. Each unit is a three-state machine. ST_COUNT is counter mode. ST_T_IDLE is timer mode, stopped. ST_T_RUN is timer mode, running. The transitions are:
- ST_COUNT to ST_T_IDLE when a timer-mode write arrives.
- ST_T_IDLE or ST_T_RUN to ST_COUNT when a counter-mode write arrives.
- ST_T_IDLE to ST_T_RUN on a start without a stop.
- ST_T_RUN to ST_T_IDLE on a stop.

A mode write takes priority over start and stop.

Top module: `trig_ctmr_bank`

## Requirements
- R1: With default parameters there are two units with 51-bit values. After reset every value is 0, every unit is in counter mode, every terminal value is all-ones, and every match flag is low.
- R2: In counter mode an increment pulse raises the value by one, and the new value and its match flag are visible one clock after the pulse.
- R3: In counter mode a decrement pulse lowers the value by one, with the same one-clock latency.
- R4: A reset (clear) pulse sets the value to 0 one clock later and wins over an increment or decrement in the same cycle.
- R5: Increment and decrement together in one cycle leave the value unchanged.
- R6: The value saturates. A decrement at 0 stays at 0, and an increment or timer advance at all-ones stays at all-ones.
- R7: In timer mode a start pulse moves a stopped unit to running without advancing. A running unit then adds one per clock. A stop pulse halts it without an advance on that clock. A start and a stop together leave a stopped unit stopped.
- R8: In timer mode a clear pulse sets the value to 0 and keeps the running or stopped condition. A running unit resumes advancing on the next clock.
- R9: Start and stop have no effect in counter mode. Increment and decrement have no effect in timer mode.
- R10: match[i] is high exactly when unit i's value equals its terminal value. A terminal write (cfg_sel=1, data = terminal) changes match from the next clock.
- R11: A mode write uses cfg_sel=0, with cfg_wdata bit 0 selecting timer (1) or counter (0). The new mode governs commands from the next clock. Switching modes keeps the value, and entering timer mode leaves the unit stopped.
- R12: Units are independent. rd_value shows, in the same cycle, the value of the unit named by rd_unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_inc | input | N_UNITS | Increment pulse per unit |
| cmd_dec | input | N_UNITS | Decrement pulse per unit |
| cmd_clr | input | N_UNITS | Clear-to-zero pulse per unit |
| cmd_start | input | N_UNITS | Timer start pulse per unit |
| cmd_stop | input | N_UNITS | Timer stop pulse per unit |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_unit | input | UNIT_W | Unit addressed by the write |
| cfg_sel | input | 1 | 0: mode, 1: terminal value |
| cfg_wdata | input | CNT_W | Write data |
| rd_unit | input | UNIT_W | Unit whose value is read |
| rd_value | output | CNT_W | Current value of the selected unit |
| match | output | N_UNITS | Value equals terminal, per unit |

## Verification
A unit whose state register is wrong shows it at rd_value within one or two clocks. It may keep advancing after a stop, fail to start, or react to commands of the other mode. Value-path faults such as lost saturation, wrong priority between clear and stepping, or a missing cancel appear on the clock right after the command. A faulty comparator shows up as a match flag that disagrees with a read value the bench can predict exactly. Because every check follows one command with one clock of latency, a fault shows up on the first scenario that touches it.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        ST_COUNT  = 2'd0,
        ST_T_IDLE = 2'd1,
        ST_T_RUN  = 2'd2
    } ctmr_state_e;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_TIMER = 1'b1
    } ctmr_mode_e;

    typedef struct packed {
        logic inc;
        logic dec;
        logic clr;
        logic start;
        logic stop;
    } ctmr_cmd_t;

endpackage

// File: rtl/ctmr_term_regs.sv
module ctmr_term_regs #(
    parameter int N      = 2,
    parameter int W      = 51,
    parameter int UNIT_W = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  sel,
    input  logic [UNIT_W-1:0]     unit,
    input  logic [W-1:0]          wdata,
    output logic [N-1:0][W-1:0]   term
);

    for (genvar i = 0; i < N; i++) begin : g_term
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                term[i] <= '1;
            end else if (wr && sel && (unit == UNIT_W'(i))) begin
                term[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int W = 51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_set,
    input  ctmr_mode_e        mode_val,
    input  ctmr_cmd_t         cmd,
    input  logic [W-1:0]      term,
    output logic [W-1:0]      val,
    output logic              match,
    output ctmr_state_e       state
);

    localparam logic [W-1:0] VAL_MAX = '1;
    localparam logic [W-1:0] VAL_ONE = W'(1);

    ctmr_state_e  state_nxt;
    logic [W-1:0] val_q;
    logic [W-1:0] val_nxt;
    logic         at_max;
    logic         at_zero;

    assign at_max  = (val_q == VAL_MAX);
    assign at_zero = (val_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COUNT;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_COUNT: begin
                if (mode_set && mode_val == MODE_TIMER) state_nxt = ST_T_IDLE;
            end
            ST_T_IDLE: begin
                if (mode_set && mode_val == MODE_COUNT) state_nxt = ST_COUNT;
                else if (cmd.start && !cmd.stop)        state_nxt = ST_T_RUN;
            end
            ST_T_RUN: begin
                if (mode_set && mode_val == MODE_COUNT) state_nxt = ST_COUNT;
                else if (cmd.stop)                      state_nxt = ST_T_IDLE;
            end
            default: state_nxt = ST_COUNT;
        endcase
    end

    // value update per state
    always_comb begin
        val_nxt = val_q;
        unique case (state)
            ST_COUNT: begin
                if (cmd.clr)                                   val_nxt = '0;
                else if (cmd.inc && !cmd.dec && !at_max)       val_nxt = val_q + VAL_ONE;
                else if (cmd.dec && !cmd.inc && !at_zero)      val_nxt = val_q - VAL_ONE;
            end
            ST_T_IDLE: begin
                if (cmd.clr) val_nxt = '0;
            end
            ST_T_RUN: begin
                if (cmd.clr)                       val_nxt = '0;
                else if (!cmd.stop && !at_max)     val_nxt = val_q + VAL_ONE;
            end
            default: val_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_nxt;
        end
    end

    assign val   = val_q;
    assign match = (val_q == term);

endmodule

// File: rtl/trig_ctmr_bank.sv
module trig_ctmr_bank
    import ctmr_pkg::*;
#(
    parameter int N_UNITS = 2,
    parameter int CNT_W   = 51,
    parameter int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_UNITS-1:0]   cmd_inc,
    input  logic [N_UNITS-1:0]   cmd_dec,
    input  logic [N_UNITS-1:0]   cmd_clr,
    input  logic [N_UNITS-1:0]   cmd_start,
    input  logic [N_UNITS-1:0]   cmd_stop,
    input  logic                 cfg_wr,
    input  logic [UNIT_W-1:0]    cfg_unit,
    input  logic                 cfg_sel,
    input  logic [CNT_W-1:0]     cfg_wdata,
    input  logic [UNIT_W-1:0]    rd_unit,
    output logic [CNT_W-1:0]     rd_value,
    output logic [N_UNITS-1:0]   match
);

    logic [N_UNITS-1:0][CNT_W-1:0] unit_term;
    logic [N_UNITS-1:0][CNT_W-1:0] unit_val;
    ctmr_state_e [N_UNITS-1:0]     unit_state;
    ctmr_mode_e                    mode_val;

    assign mode_val = ctmr_mode_e'(cfg_wdata[0]);

    ctmr_term_regs #(
        .N      (N_UNITS),
        .W      (CNT_W),
        .UNIT_W (UNIT_W)
    ) u_term (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .unit  (cfg_unit),
        .wdata (cfg_wdata),
        .term  (unit_term)
    );

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        ctmr_cmd_t cmd;
        logic      mode_set;

        assign cmd.inc   = cmd_inc[i];
        assign cmd.dec   = cmd_dec[i];
        assign cmd.clr   = cmd_clr[i];
        assign cmd.start = cmd_start[i];
        assign cmd.stop  = cmd_stop[i];
        assign mode_set  = cfg_wr && !cfg_sel && (cfg_unit == UNIT_W'(i));

        ctmr_core #(.W(CNT_W)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_set (mode_set),
            .mode_val (mode_val),
            .cmd      (cmd),
            .term     (unit_term[i]),
            .val      (unit_val[i]),
            .match    (match[i]),
            .state    (unit_state[i])
        );
    end

    always_comb begin
        rd_value = '0;
        for (int k = 0; k < N_UNITS; k++) begin
            if (rd_unit == UNIT_W'(k)) rd_value = unit_val[k];
        end
    end

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk
    import ctmr_pkg::*;
#(
    parameter int N = 2,
    parameter int W = 51
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         cmd_inc,
    input  logic [N-1:0]         cmd_dec,
    input  logic [N-1:0]         cmd_clr,
    input  logic [N-1:0]         cmd_stop,
    input  logic [N-1:0][W-1:0]  unit_val,
    input  ctmr_state_e [N-1:0]  unit_state
);

    localparam logic [W-1:0] VMAX = '1;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R4
        clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_clr[g] |=> unit_val[g] == '0);

        // R2
        inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_state[g] == ST_COUNT && cmd_inc[g] && !cmd_dec[g] && !cmd_clr[g]
             && unit_val[g] != VMAX)
            |=> unit_val[g] == $past(unit_val[g]) + W'(1));

        // R6
        floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_state[g] == ST_COUNT && cmd_dec[g] && !cmd_clr[g] && unit_val[g] == '0)
            |=> unit_val[g] == '0);

        // R5
        cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_state[g] == ST_COUNT && cmd_inc[g] && cmd_dec[g] && !cmd_clr[g])
            |=> $stable(unit_val[g]));

        // R7
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_state[g] == ST_T_IDLE && !cmd_clr[g]) |=> $stable(unit_val[g]));

        // R7
        run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_state[g] == ST_T_RUN && !cmd_clr[g] && !cmd_stop[g] && unit_val[g] != VMAX)
            |=> unit_val[g] == $past(unit_val[g]) + W'(1));
    end

endmodule

bind trig_ctmr_bank ctmr_chk #(.N(N_UNITS), .W(CNT_W)) u_ctmr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_inc    (cmd_inc),
    .cmd_dec    (cmd_dec),
    .cmd_clr    (cmd_clr),
    .cmd_stop   (cmd_stop),
    .unit_val   (unit_val),
    .unit_state (unit_state)
);

// File: tb/tb_trig_ctmr_bank.sv
`timescale 1ns/1ps
module tb_trig_ctmr_bank;

    localparam int W  = 51;
    localparam int SW = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   inc = '0, dec = '0, clr = '0, start = '0, stop = '0;
    logic         cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [0:0]   cfg_unit = '0, rd_unit = '0;
    logic [W-1:0] cfg_wdata = '0;
    logic [W-1:0] rd_value;
    logic [1:0]   match;

    logic          s_inc = 1'b0;
    logic [SW-1:0] s_val;
    logic [0:0]    s_match;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trig_ctmr_bank dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_inc(inc), .cmd_dec(dec), .cmd_clr(clr), .cmd_start(start), .cmd_stop(stop),
        .cfg_wr(cfg_wr), .cfg_unit(cfg_unit), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_unit(rd_unit), .rd_value(rd_value), .match(match)
    );

    trig_ctmr_bank #(.N_UNITS(1), .CNT_W(SW)) dut_small (
        .clk(clk), .rst_n(rst_n),
        .cmd_inc(s_inc), .cmd_dec(1'b0), .cmd_clr(1'b0), .cmd_start(1'b0), .cmd_stop(1'b0),
        .cfg_wr(1'b0), .cfg_unit(1'b0), .cfg_sel(1'b0), .cfg_wdata('0),
        .rd_unit(1'b0), .rd_value(s_val), .match(s_match)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cmd(input int u, input logic i, input logic d, input logic c,
                       input logic s, input logic p);
        inc[u] = i; dec[u] = d; clr[u] = c; start[u] = s; stop[u] = p;
        tick();
        inc = '0; dec = '0; clr = '0; start = '0; stop = '0;
    endtask

    task automatic cfg(input int u, input logic sel, input logic [W-1:0] data);
        cfg_wr = 1'b1; cfg_unit = 1'(u); cfg_sel = sel; cfg_wdata = data;
        tick();
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic val_is(input string tag, input int u, input logic [W-1:0] exp);
        rd_unit = 1'(u);
        #0.5;
        check(tag, rd_value, exp);
    endtask

    task automatic t_reset();
        check("R1 width", W'($bits(rd_value)), W'(51));
        check("R1 units", W'($bits(match)), W'(2));
        val_is("R1 val0", 0, '0);
        val_is("R1 val1", 1, '0);
        check("R1 match", W'(match), '0);
    endtask

    task automatic t_counter();
        cfg(0, 1'b1, W'(3));
        cmd(0, 1, 0, 0, 0, 0);
        cmd(0, 1, 0, 0, 0, 0);
        val_is("R2 two incs", 0, W'(2));
        check("R10 no match at 2", W'(match[0]), '0);
        cmd(0, 1, 0, 0, 0, 0);
        val_is("R2 three incs", 0, W'(3));
        check("R10 match at 3", W'(match[0]), W'(1));
        cmd(0, 0, 1, 0, 0, 0);
        val_is("R3 dec", 0, W'(2));
        check("R10 match drops", W'(match[0]), '0);
        cmd(0, 1, 1, 0, 0, 0);
        val_is("R5 cancel", 0, W'(2));
        cmd(0, 1, 0, 1, 0, 0);
        val_is("R4 clr beats inc", 0, '0);
        cmd(0, 0, 1, 0, 0, 0);
        val_is("R6 floor", 0, '0);
        cmd(0, 0, 0, 0, 1, 0);
        idle(3);
        val_is("R9 start ignored in counter mode", 0, '0);
        cfg(0, 1'b1, '0);
        check("R10 terminal write", W'(match[0]), W'(1));
    endtask

    task automatic t_timer();
        cfg(1, 1'b0, W'(1));
        cmd(1, 1, 0, 0, 0, 0);
        val_is("R9 inc ignored in timer mode", 1, '0);
        cmd(1, 0, 0, 0, 1, 0);
        val_is("R7 no advance on start", 1, '0);
        idle(4);
        cmd(1, 0, 0, 0, 0, 1);
        val_is("R7 four clocks run", 1, W'(4));
        idle(3);
        val_is("R7 held after stop", 1, W'(4));
        cmd(1, 0, 0, 0, 1, 1);
        idle(2);
        val_is("R7 start+stop stays stopped", 1, W'(4));
        cmd(1, 0, 0, 0, 1, 0);
        idle(2);
        val_is("R7 resume", 1, W'(6));
        cmd(1, 0, 0, 1, 0, 0);
        val_is("R8 clr while running", 1, '0);
        idle(1);
        val_is("R8 keeps running", 1, W'(1));
        val_is("R12 unit0 untouched", 0, '0);
        check("R12 unit0 match", W'(match[0]), W'(1));
    endtask

    task automatic t_switch();
        cfg(1, 1'b0, W'(0));
        val_is("R11 advance in write cycle", 1, W'(2));
        idle(2);
        val_is("R11 value kept, counter mode", 1, W'(2));
        cmd(1, 0, 0, 0, 1, 0);
        idle(1);
        val_is("R9 start ignored after switch", 1, W'(2));
        cmd(1, 1, 0, 0, 0, 0);
        val_is("R11 inc in counter mode", 1, W'(3));
        cfg(1, 1'b0, W'(1));
        idle(2);
        val_is("R11 timer entry is stopped", 1, W'(3));
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 63; i++) begin
            s_inc = 1'b1;
            tick();
        end
        s_inc = 1'b0;
        check("R6 reach top", W'(s_val), W'(63));
        s_inc = 1'b1;
        tick();
        tick();
        s_inc = 1'b0;
        check("R6 ceiling", W'(s_val), W'(63));
    endtask

    initial begin
        #20000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_counter();
        t_timer();
        t_switch();
        t_saturate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule